// File: doc/BRIEF.md
# Variable-length CAN receive FIFO

This block is the receive store of a CAN controller. Each accepted frame arrives on a parallel write side as format, RTR, length code, identifier and payload. It is packed into a variable-length byte record in a circular byte memory. Every record opens with a header byte. Identifier bytes follow, then the payload bytes. Because the header carries the record's own length, a single release command can step over the oldest record without any side table.

Software, or a neighbouring bus interface, reads the oldest record through a small byte window placed relative to the start pointer. When it has finished with the record, it issues a release. The block keeps a byte count, a message count and a sticky overrun flag. It also raises a pending indication while any record is held, and an active indication while an incoming frame is being checked or written. A frame that does not fit is dropped whole.

Top module: `canrx_fifo`

## Requirements
- R1: After reset, byte_cnt and msg_cnt are 0, and rx_pending, ovr_flag and rx_active are all low.
- R2: Byte 0 of every record is the header: bit 7 = extended format, bit 6 = RTR, bits 5:4 = 0, bits 3:0 = length code clamped to 8.
- R3: An extended record is laid out as the header, then id[28:21], id[20:13], id[12:5], then {id[4:0], 3'b000}, with payload from byte 5 on. Payload byte k is wr_data[8k+7:8k].
- R4: A standard record is laid out as the header, then id[10:3], then {id[2:0], 5'b00000}, with payload from byte 3 on. A length code above 8 stores 8 payload bytes.
- R5: An RTR frame stores no payload bytes. Its record length is 3 for standard format and 5 for extended.
- R6: A wr_valid pulse seen while rx_active is low starts a store, and rx_active is high from the next cycle until the frame is stored or dropped. On a successful store, byte_cnt grows by the record length, msg_cnt grows by 1 and rx_pending is set. A wr_valid pulse seen while rx_active is high is ignored.
- R7: If byte_cnt plus the record length would exceed CAP, the frame is dropped: ovr_flag is set and both counts are unchanged. A pulse on ovr_clr clears ovr_flag. If both happen in the same cycle, setting wins.
- R8: A release takes the oldest record's length from its header, moves the start pointer forward by that length modulo CAP, subtracts the length from byte_cnt and decrements msg_cnt. The window then shows the next record.
- R9: A release while msg_cnt is 0 changes nothing.
- R10: rx_pending clears when msg_cnt returns to 0.
- R11: rd_data, one cycle after rd_off is applied, is the byte at (start + rd_off) mod CAP for rd_off 0 to 12, and 0 for rd_off 13 to 15.
- R12: A release requested during a store takes effect after that store completes. Several requests made before one is carried out merge into a single release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Frame offered this cycle |
| wr_ext | input | 1 | Extended identifier format |
| wr_rtr | input | 1 | Remote request frame |
| wr_dlc | input | 4 | Length code |
| wr_id | input | 29 | Identifier; standard frames use bits 10:0 |
| wr_data | input | 64 | Payload, byte k in bits 8k+7:8k |
| rel_req | input | 1 | Release the oldest record |
| ovr_clr | input | 1 | Clear the overrun flag |
| rd_off | input | 4 | Byte offset into the oldest record |
| rd_data | output | 8 | Window byte, one cycle after rd_off |
| rx_pending | output | 1 | At least one record is held |
| ovr_flag | output | 1 | A frame was dropped for lack of room |
| rx_active | output | 1 | A frame is being checked or stored |
| byte_cnt | output | CW | Bytes held |
| msg_cnt | output | CW | Records held |

## Verification
The assertions assume a frame is offered only while rx_active is low, and that CAP is at least 13, so that one step of a pointer never wraps more than once. The stimulus always waits for rx_active to fall before it offers the next frame. It pulses the release and overrun-clear inputs for one cycle at a time, and it reads the window only while the block is quiet, so that every observed value comes from a settled state.

// File: rtl/canrx_pkg.sv
package canrx_pkg;
  localparam int ID_W     = 29;
  localparam int MAX_DATA = 8;
  localparam int MAX_REC  = 5 + MAX_DATA;

  typedef struct packed {
    logic                    ext;
    logic                    rtr;
    logic [3:0]              dlc;
    logic [ID_W-1:0]         id;
    logic [8*MAX_DATA-1:0]   data;
  } frame_t;

  typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_STORE, ST_REL} ctl_state_e;

  function automatic logic [3:0] payload_len(input logic rtr, input logic [3:0] dlc);
    if (rtr) return 4'd0;
    return (dlc > 4'd8) ? 4'd8 : dlc;
  endfunction

  function automatic logic [3:0] rec_len(input logic ext, input logic rtr,
                                         input logic [3:0] dlc);
    return 4'd3 + (ext ? 4'd2 : 4'd0) + payload_len(rtr, dlc);
  endfunction

  function automatic int wrap_idx(input int base, input int off, input int cap);
    int s;
    s = base + off;
    if (s >= cap) s = s - cap;
    return s;
  endfunction
endpackage

// File: rtl/canrx_bytemem.sv
module canrx_bytemem #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/canrx_serializer.sv
module canrx_serializer
  import canrx_pkg::*;
(
  input  frame_t     frm,
  input  logic [3:0] idx,
  output logic [7:0] byte_o,
  output logic [3:0] len_o
);
  logic [3:0] dlc_c;
  logic [3:0] dstart;
  logic [3:0] k;

  always_comb begin
    dlc_c  = (frm.dlc > 4'd8) ? 4'd8 : frm.dlc;
    len_o  = rec_len(frm.ext, frm.rtr, frm.dlc);
    dstart = frm.ext ? 4'd5 : 4'd3;
    k      = idx - dstart;
    byte_o = 8'h00;
    if (idx == 4'd0) begin
      byte_o = {frm.ext, frm.rtr, 2'b00, dlc_c};
    end else if (frm.ext && idx < 4'd5) begin
      case (idx)
        4'd1:    byte_o = frm.id[28:21];
        4'd2:    byte_o = frm.id[20:13];
        4'd3:    byte_o = frm.id[12:5];
        default: byte_o = {frm.id[4:0], 3'b000};
      endcase
    end else if (!frm.ext && idx < 4'd3) begin
      byte_o = (idx == 4'd1) ? frm.id[10:3] : {frm.id[2:0], 5'b00000};
    end else if (k < 4'd8) begin
      byte_o = frm.data[{k[2:0], 3'b000} +: 8];
    end
  end
endmodule

// File: rtl/canrx_ctrl.sv
module canrx_ctrl
  import canrx_pkg::*;
#(
  parameter int CAP = 64,
  parameter int AW  = $clog2(CAP),
  parameter int CW  = $clog2(CAP + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  input  frame_t        frm_in,
  input  logic          rel_req,
  input  logic          ovr_clr,
  input  logic [7:0]    hdr_q,
  input  logic [3:0]    ser_len,
  output frame_t        frm_q,
  output logic [3:0]    idx,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] start_ptr,
  output logic [CW-1:0] byte_cnt,
  output logic [CW-1:0] msg_cnt,
  output logic          rx_pending,
  output logic          ovr_flag,
  output logic          rx_active
);
  localparam int CW1 = CW + 1;

  ctl_state_e    state;
  logic [AW-1:0] wr_ptr;
  logic          rel_pend;
  logic          fits;
  logic [3:0]    hdr_len;

  assign fits    = ({1'b0, byte_cnt} + CW1'(ser_len)) <= CW1'(CAP);
  assign hdr_len = rec_len(hdr_q[7], hdr_q[6], hdr_q[3:0]);
  assign we      = (state == ST_STORE);
  assign waddr   = AW'(wrap_idx(int'(wr_ptr), int'(idx), CAP));

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      frm_q      <= '0;
      idx        <= '0;
      wr_ptr     <= '0;
      start_ptr  <= '0;
      byte_cnt   <= '0;
      msg_cnt    <= '0;
      rx_pending <= 1'b0;
      ovr_flag   <= 1'b0;
      rx_active  <= 1'b0;
      rel_pend   <= 1'b0;
    end else begin
      if (ovr_clr) ovr_flag <= 1'b0;
      if (wr_valid && !rx_active) begin
        frm_q     <= frm_in;
        rx_active <= 1'b1;
      end
      case (state)
        ST_IDLE: begin
          if (rel_pend) begin
            rel_pend <= 1'b0;
            if (msg_cnt != '0) state <= ST_REL;
          end else if (rx_active) begin
            state <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (fits) begin
            idx   <= '0;
            state <= ST_STORE;
          end else begin
            ovr_flag  <= 1'b1;
            rx_active <= 1'b0;
            state     <= ST_IDLE;
          end
        end
        ST_STORE: begin
          if (idx == ser_len - 4'd1) begin
            wr_ptr     <= AW'(wrap_idx(int'(wr_ptr), int'(ser_len), CAP));
            byte_cnt   <= byte_cnt + CW'(ser_len);
            msg_cnt    <= msg_cnt + CW'(1);
            rx_pending <= 1'b1;
            rx_active  <= 1'b0;
            state      <= ST_IDLE;
          end else begin
            idx <= idx + 4'd1;
          end
        end
        default: begin
          start_ptr <= AW'(wrap_idx(int'(start_ptr), int'(hdr_len), CAP));
          byte_cnt  <= byte_cnt - CW'(hdr_len);
          msg_cnt   <= msg_cnt - CW'(1);
          if (msg_cnt == CW'(1)) rx_pending <= 1'b0;
          state <= ST_IDLE;
        end
      endcase
      if (rel_req) rel_pend <= 1'b1;
    end
  end

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    byte_cnt <= CW'(CAP));
  // R10
  pending_match_chk: assert property (@(posedge clk) disable iff (rst)
    rx_pending == (msg_cnt != '0));
  // R8
  empty_match_chk: assert property (@(posedge clk) disable iff (rst)
    (msg_cnt == '0) == (byte_cnt == '0));
  // R9
  rel_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_REL) |-> (msg_cnt != '0));
  // R2
  hdr_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_REL) |-> (hdr_q[5:4] == 2'b00 && hdr_q[3:0] <= 4'd8));
  // R7
  ovr_keep_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_flag) |-> ($stable(byte_cnt) && $stable(msg_cnt)));
  // R12
  no_rel_in_store_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STORE) |=> $stable(start_ptr));
  // R6
  act_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_active) |-> ((msg_cnt != $past(msg_cnt)) || ovr_flag));
endmodule

// File: rtl/canrx_fifo.sv
module canrx_fifo
  import canrx_pkg::*;
#(
  parameter int CAP = 64,
  parameter int WIN = 13,
  localparam int AW = $clog2(CAP),
  localparam int CW = $clog2(CAP + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  input  logic          wr_ext,
  input  logic          wr_rtr,
  input  logic [3:0]    wr_dlc,
  input  logic [28:0]   wr_id,
  input  logic [63:0]   wr_data,
  input  logic          rel_req,
  input  logic          ovr_clr,
  input  logic [3:0]    rd_off,
  output logic [7:0]    rd_data,
  output logic          rx_pending,
  output logic          ovr_flag,
  output logic          rx_active,
  output logic [CW-1:0] byte_cnt,
  output logic [CW-1:0] msg_cnt
);
  localparam int NPORT = 2;

  frame_t        frm_in, frm_q;
  logic [3:0]    idx, ser_len;
  logic [7:0]    ser_byte;
  logic          we;
  logic [AW-1:0] waddr, start_ptr;
  logic [AW-1:0] raddr [NPORT];
  logic [7:0]    rdq   [NPORT];
  logic          in_win_q;

  assign frm_in = '{ext: wr_ext, rtr: wr_rtr, dlc: wr_dlc, id: wr_id, data: wr_data};

  canrx_serializer u_ser (
    .frm(frm_q), .idx(idx), .byte_o(ser_byte), .len_o(ser_len)
  );

  canrx_ctrl #(.CAP(CAP), .AW(AW), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .frm_in(frm_in),
    .rel_req(rel_req), .ovr_clr(ovr_clr), .hdr_q(rdq[1]), .ser_len(ser_len),
    .frm_q(frm_q), .idx(idx), .we(we), .waddr(waddr), .start_ptr(start_ptr),
    .byte_cnt(byte_cnt), .msg_cnt(msg_cnt), .rx_pending(rx_pending),
    .ovr_flag(ovr_flag), .rx_active(rx_active)
  );

  // Port 0 serves the read window, port 1 the header for release.
  assign raddr[0] = AW'(wrap_idx(int'(start_ptr), int'(rd_off), CAP));
  assign raddr[1] = start_ptr;

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    canrx_bytemem #(.DEPTH(CAP), .AW(AW)) u_mem (
      .clk(clk), .we(we), .waddr(waddr), .wdata(ser_byte),
      .raddr(raddr[g]), .rdata(rdq[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) in_win_q <= 1'b0;
    else     in_win_q <= (int'(rd_off) < WIN);
  end

  assign rd_data = in_win_q ? rdq[0] : 8'h00;

  // R5
  len_range_chk: assert property (@(posedge clk) disable iff (rst)
    we |-> (ser_len >= 4'd3 && ser_len <= 4'(MAX_REC)));
  // R11
  win_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(rd_off) >= WIN) |=> (rd_data == 8'h00));
endmodule

// File: tb/test_canrx_fifo.sv
`timescale 1ns/1ps
module test_canrx_fifo;
  localparam int CAP = 64;
  localparam int CW  = $clog2(CAP + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_valid = 1'b0, wr_ext = 1'b0, wr_rtr = 1'b0;
  logic [3:0]  wr_dlc = '0;
  logic [28:0] wr_id = '0;
  logic [63:0] wr_data = '0;
  logic rel_req = 1'b0, ovr_clr = 1'b0;
  logic [3:0] rd_off = '0;
  logic [7:0] rd_data;
  logic rx_pending, ovr_flag, rx_active;
  logic [CW-1:0] byte_cnt, msg_cnt;

  always #2.5 clk = ~clk;

  canrx_fifo #(.CAP(CAP)) i_canrx_fifo (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ext(wr_ext), .wr_rtr(wr_rtr),
    .wr_dlc(wr_dlc), .wr_id(wr_id), .wr_data(wr_data), .rel_req(rel_req),
    .ovr_clr(ovr_clr), .rd_off(rd_off), .rd_data(rd_data),
    .rx_pending(rx_pending), .ovr_flag(ovr_flag), .rx_active(rx_active),
    .byte_cnt(byte_cnt), .msg_cnt(msg_cnt)
  );

  logic [7:0] m_mem [CAP];
  bit         m_vld [CAP];
  int m_start = 0, m_wr = 0, m_bytes = 0, m_msgs = 0;
  bit m_ovr = 0;
  int checks = 0, fails = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int b_len(bit e, bit r, logic [3:0] dlc);
    int d;
    d = r ? 0 : ((dlc > 4'd8) ? 8 : int'(dlc));
    return 3 + (e ? 2 : 0) + d;
  endfunction

  function automatic logic [7:0] b_byte(bit e, bit r, logic [3:0] dlc, logic [28:0] id,
                                        logic [63:0] d, int i);
    logic [3:0] dc;
    int ds;
    dc = (dlc > 4'd8) ? 4'd8 : dlc;
    ds = e ? 5 : 3;
    if (i == 0) return {e, r, 2'b00, dc};
    if (e) begin
      if (i == 1) return id[28:21];
      if (i == 2) return id[20:13];
      if (i == 3) return id[12:5];
      if (i == 4) return {id[4:0], 3'b000};
    end else begin
      if (i == 1) return id[10:3];
      if (i == 2) return {id[2:0], 5'b00000};
    end
    return d[8*(i-ds) +: 8];
  endfunction

  function automatic void m_store(bit e, bit r, logic [3:0] dlc, logic [28:0] id, logic [63:0] d);
    int len;
    len = b_len(e, r, dlc);
    if (m_bytes + len > CAP) begin
      m_ovr = 1;
    end else begin
      for (int i = 0; i < len; i++) begin
        m_mem[(m_wr + i) % CAP] = b_byte(e, r, dlc, id, d, i);
        m_vld[(m_wr + i) % CAP] = 1;
      end
      m_wr = (m_wr + len) % CAP;
      m_bytes += len;
      m_msgs++;
    end
  endfunction

  function automatic void m_release();
    logic [7:0] h;
    int len;
    if (m_msgs == 0) return;
    h = m_mem[m_start];
    len = b_len(h[7], h[6], h[3:0]);
    m_start = (m_start + len) % CAP;
    m_bytes -= len;
    m_msgs--;
  endfunction

  task automatic wait_idle();
    int n = 0;
    while (rx_active && n < 100) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic do_store(bit e, bit r, logic [3:0] dlc, logic [28:0] id, logic [63:0] d,
                          bit with_rel);
    @(negedge clk);
    wr_ext = e; wr_rtr = r; wr_dlc = dlc; wr_id = id; wr_data = d; wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    if (with_rel) begin
      rel_req = 1'b1;
      // R12: a second frame offered mid-store must be ignored
      wr_valid = 1'b1; wr_id = ~id;
      @(negedge clk);
      rel_req = 1'b0; wr_valid = 1'b0;
    end
    wait_idle();
    repeat (4) @(negedge clk);
    m_store(e, r, dlc, id, d);
    if (with_rel) m_release();
  endtask

  task automatic do_release();
    @(negedge clk); rel_req = 1'b1;
    @(negedge clk); rel_req = 1'b0;
    repeat (3) @(negedge clk);
    m_release();
  endtask

  task automatic do_ovr_clr();
    @(negedge clk); ovr_clr = 1'b1;
    @(negedge clk); ovr_clr = 1'b0;
    m_ovr = 0;
  endtask

  task automatic check_state(string req);
    chk(req, "byte_cnt", 32'(byte_cnt), 32'(m_bytes));
    chk(req, "msg_cnt", 32'(msg_cnt), 32'(m_msgs));
    chk("R10", "rx_pending", 32'(rx_pending), 32'(m_msgs != 0));
    chk("R7", "ovr_flag", 32'(ovr_flag), 32'(m_ovr));
    chk("R6", "rx_active", 32'(rx_active), 32'd0);
  endtask

  task automatic check_window(string req);
    for (int off = 0; off < 16; off++) begin
      @(negedge clk); rd_off = 4'(off);
      @(negedge clk);
      if (off > 12) chk("R11", "window beyond", 32'(rd_data), 32'd0);
      else if (m_vld[(m_start + off) % CAP])
        chk(req, "window byte", 32'(rd_data), 32'(m_mem[(m_start + off) % CAP]));
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R6 watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    int r;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < CAP; i++) m_vld[i] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_state("R1");

    do_release();
    check_state("R9");

    do_store(1, 0, 4'd8, 29'h1234_5678, 64'h8877_6655_4433_2211, 0);
    check_state("R3");
    @(negedge clk); rd_off = 4'd0; @(negedge clk);
    chk("R2", "ext header", 32'(rd_data), 32'h88);
    check_window("R3");
    do_release();
    check_state("R8");

    do_store(0, 0, 4'd12, 29'h0000_05A3, 64'hF0E1_D2C3_B4A5_9687, 0);
    check_state("R4");
    @(negedge clk); rd_off = 4'd0; @(negedge clk);
    chk("R4", "clamped header", 32'(rd_data), 32'h08);
    check_window("R4");
    do_store(0, 1, 4'd5, 29'h0000_0123, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    check_state("R5");
    do_release();
    check_window("R5");
    do_release();
    check_state("R10");

    for (int i = 0; i < 5; i++) do_store(1, 0, 4'd8, 29'(i * 7919), {2{32'(i)}}, 0);
    check_state("R7");
    do_ovr_clr();
    check_state("R7");
    do_store(1, 0, 4'd8, 29'h1, 64'h0, 1);
    check_state("R12");
    check_window("R8");
    while (m_msgs > 0) do_release();
    check_state("R10");

    for (int it = 0; it < 250; it++) begin
      r = int'($urandom % 100);
      if (r < 55)
        do_store(($urandom % 3) == 0, ($urandom % 5) == 0, 4'($urandom), 29'($urandom),
                 {$urandom, $urandom}, 0);
      else if (r < 88) do_release();
      else if (r < 94) do_ovr_clr();
      else do_store($urandom % 2 == 0, 0, 4'($urandom), 29'($urandom), {$urandom, $urandom}, 1);
      check_state("R8");
      check_window("R11");
    end
    finish_run();
  end
endmodule